// File: doc/BRIEF.md
# Thermal Throttle Controller

The controller watches an over-temperature flag from an on-die sensor. When the die runs hot, it asks an external transition sequencer to move to a lower operating point that software has programmed beforehand. Before that request goes out, the controller records the operating point currently in effect. Once the down transition completes, a hold timer runs for a fixed number of cycles. At the end of the hold the controller samples the temperature flag again. If the die has cooled, it asks the sequencer to go back to the recorded point. If the die is still hot, it stays throttled and starts a fresh hold.

Each completed down or up thermal transition sets an interrupt. A status bit records the direction of that transition. Software target writes that arrive while a transition or a throttle is under way are not lost and do not disturb the restore point. The latest such write is kept and requested once the controller is back in normal operation. Only one sequencer request is outstanding at any time, and the sequencer completes each request with a single-cycle acknowledge.

Top module: `thr_throttle_ctrl`

## Requirements
- R1: After reset the request and interrupt outputs are low, the direction bit is 0, and the current point equals the RESET_PT parameter.
- R2: In normal operation a software target write leads to a sequencer request for that point. The current point takes the requested value on the acknowledge. No interrupt is raised.
- R3: With hot_i high in normal operation, the controller requests the value held in the throttle point register. It also stores the point in effect at that time as the restore point.
- R4: An issued request stays high with an unchanged point until ack_i. No new request is issued before then.
- R5: After the down acknowledge, the temperature is rechecked exactly HOLD_CYC cycles later. If hot_i is low at that check, a request for the restore point follows in the same cycle.
- R6: If hot_i is still high at the check, the controller stays throttled and waits another full HOLD_CYC cycles before the next check.
- R7: Completion of a down transition sets irq_o with irq_up_o = 0. Completion of an up transition sets irq_o with irq_up_o = 1. irq_o stays set until irq_clr_i is high, and a new event in the same cycle wins over the clear.
- R8: Software target writes made while not in normal operation leave the restore point unchanged. Only the latest of them is requested, one cycle after the return to normal operation.
- R9: A write to the throttle point register takes effect at the next throttle entry after the write cycle.
- R10: If hot_i and a pending software target coincide in normal operation, the throttle goes first. The software target is requested after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hot_i | input | 1 | Over-temperature flag from the sensor |
| tgt_wr_i | input | 1 | Software target point write strobe |
| tgt_pt_i | input | PW | Software target point |
| thr_wr_i | input | 1 | Throttle point register write strobe |
| thr_pt_i | input | PW | Throttle point value |
| ack_i | input | 1 | Sequencer completion acknowledge, one cycle |
| req_o | output | 1 | Transition request to the sequencer |
| req_pt_o | output | PW | Requested operating point |
| cur_pt_o | output | PW | Operating point currently in effect |
| irq_o | output | 1 | Thermal transition interrupt pending |
| irq_up_o | output | 1 | Direction of last interrupt (0 down, 1 up) |
| irq_clr_i | input | 1 | Write-one-to-clear of the interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- a request holds steady until it is acknowledged;
- the current point takes the acknowledged value;
- the throttle point is chosen on entry;
- no up request leaves the hold state except at a cool expiry;
- the restore point stays fixed against software writes;
- the interrupt is sticky and its direction bit is correct.

Other behaviours can only be shown by the bench's scenarios, with a sequencer model that checks the order of requests against a queue of expected requests:
- the exact hold length, and its doubling while the die stays hot;
- the order of throttle, restore and queued software requests;
- replacement of one queued target by a later write;
- the moment at which a new throttle point takes effect.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_SW_WAIT,
    ST_DOWN_WAIT,
    ST_HOLD,
    ST_UP_WAIT
  } thr_state_e;

  // Width of a counter that must reach n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/thr_hold_timer.sv
module thr_hold_timer #(
  parameter int unsigned HOLD_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic expire_o
);
  localparam int unsigned CW = thr_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + CW'(1);
  endfunction

  assign expire_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= step(cnt_q);
    else           cnt_q <= '0;
  end

  // The hold window restarts after an expiry, so two expiries are never adjacent (R6)
  p_no_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (HOLD_CYC > 1 && expire_o) |=> !expire_o);

  // While running and not expiring, the count advances by one (R5)
  p_count_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !expire_o) |=> (!en_i || cnt_q != '0));
endmodule

// File: rtl/thr_irq_status.sv
module thr_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_down_i,
  input  logic ev_up_i,
  input  logic clr_i,
  output logic irq_o,
  output logic irq_up_o
);
  logic any_ev;
  assign any_ev = ev_down_i || ev_up_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o    <= 1'b0;
      irq_up_o <= 1'b0;
    end else if (any_ev) begin
      irq_o    <= 1'b1;
      irq_up_o <= ev_up_i;
    end else if (clr_i) begin
      irq_o    <= 1'b0;
    end
  end

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o);

  p_irq_down_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_down_i |=> (irq_o && !irq_up_o));

  p_irq_up_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_up_i |=> (irq_o && irq_up_o));

  p_irq_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_down_i && ev_up_i));
endmodule

// File: rtl/thr_seq_fsm.sv
module thr_seq_fsm #(
  parameter int unsigned PW          = 4,
  parameter int unsigned RESET_PT    = 8,
  parameter int unsigned THR_RESET_PT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hot_i,
  input  logic          tgt_wr_i,
  input  logic [PW-1:0] tgt_pt_i,
  input  logic          thr_wr_i,
  input  logic [PW-1:0] thr_pt_i,
  input  logic          ack_i,
  input  logic          tmr_expire_i,
  output logic          req_o,
  output logic [PW-1:0] req_pt_o,
  output logic [PW-1:0] cur_pt_o,
  output logic          hold_en_o,
  output logic          ev_down_o,
  output logic          ev_up_o
);
  import thr_pkg::*;

  localparam logic [PW-1:0] RST_PT = PW'(RESET_PT);
  localparam logic [PW-1:0] RST_TH = PW'(THR_RESET_PT);

  thr_state_e    st_q;
  logic [PW-1:0] thr_q;
  logic [PW-1:0] saved_q;
  logic          pend_v_q;
  logic [PW-1:0] pend_pt_q;

  // Named internal events
  logic start_down, take_pend, cool_expire, ack_any;
  assign start_down  = (st_q == ST_NORMAL) && hot_i;
  assign take_pend   = (st_q == ST_NORMAL) && !hot_i && pend_v_q;
  assign cool_expire = (st_q == ST_HOLD) && tmr_expire_i && !hot_i;
  assign ack_any     = req_o && ack_i;
  assign hold_en_o   = (st_q == ST_HOLD);
  assign ev_down_o   = (st_q == ST_DOWN_WAIT) && ack_i;
  assign ev_up_o     = (st_q == ST_UP_WAIT) && ack_i;

  // Throttle point register and queued software target
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q     <= RST_TH;
      pend_v_q  <= 1'b0;
      pend_pt_q <= RST_PT;
    end else begin
      if (thr_wr_i) thr_q <= thr_pt_i;
      if (tgt_wr_i) begin
        pend_v_q  <= 1'b1;
        pend_pt_q <= tgt_pt_i;
      end else if (take_pend) begin
        pend_v_q  <= 1'b0;
      end
    end
  end

  // Transition sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_NORMAL;
      req_o    <= 1'b0;
      req_pt_o <= RST_PT;
      cur_pt_o <= RST_PT;
      saved_q  <= RST_PT;
    end else begin
      if (ack_any) begin
        req_o    <= 1'b0;
        cur_pt_o <= req_pt_o;
      end
      case (st_q)
        ST_NORMAL: begin
          if (start_down) begin
            req_o    <= 1'b1;
            req_pt_o <= thr_q;
            saved_q  <= cur_pt_o;
            st_q     <= ST_DOWN_WAIT;
          end else if (take_pend) begin
            req_o    <= 1'b1;
            req_pt_o <= pend_pt_q;
            st_q     <= ST_SW_WAIT;
          end
        end
        ST_SW_WAIT:   if (ack_i) st_q <= ST_NORMAL;
        ST_DOWN_WAIT: if (ack_i) st_q <= ST_HOLD;
        ST_HOLD: begin
          if (cool_expire) begin
            req_o    <= 1'b1;
            req_pt_o <= saved_q;
            st_q     <= ST_UP_WAIT;
          end
        end
        ST_UP_WAIT:   if (ack_i) st_q <= ST_NORMAL;
        default:      st_q <= ST_NORMAL;
      endcase
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(req_pt_o)));

  p_cur_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_any |=> (cur_pt_o == $past(req_pt_o)));

  p_down_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_down |=> (req_o && req_pt_o == $past(thr_q)));

  p_hold_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en_o && !(tmr_expire_i && !hot_i)) |=> !req_o);

  p_up_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cool_expire |=> (req_o && req_pt_o == saved_q));

  p_restore_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_NORMAL && tgt_wr_i) |=> $stable(saved_q));
endmodule

// File: rtl/thr_throttle_ctrl.sv
module thr_throttle_ctrl #(
  parameter int unsigned PW           = 4,
  parameter int unsigned HOLD_CYC     = 1000,
  parameter int unsigned RESET_PT     = 8,
  parameter int unsigned THR_RESET_PT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hot_i,
  input  logic          tgt_wr_i,
  input  logic [PW-1:0] tgt_pt_i,
  input  logic          thr_wr_i,
  input  logic [PW-1:0] thr_pt_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [PW-1:0] req_pt_o,
  output logic [PW-1:0] cur_pt_o,
  output logic          irq_o,
  output logic          irq_up_o,
  input  logic          irq_clr_i
);
  logic hold_en, tmr_expire, ev_down, ev_up;

  thr_seq_fsm #(
    .PW(PW), .RESET_PT(RESET_PT), .THR_RESET_PT(THR_RESET_PT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i),
    .tgt_wr_i(tgt_wr_i), .tgt_pt_i(tgt_pt_i),
    .thr_wr_i(thr_wr_i), .thr_pt_i(thr_pt_i),
    .ack_i(ack_i), .tmr_expire_i(tmr_expire),
    .req_o(req_o), .req_pt_o(req_pt_o), .cur_pt_o(cur_pt_o),
    .hold_en_o(hold_en), .ev_down_o(ev_down), .ev_up_o(ev_up)
  );

  thr_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(hold_en), .expire_o(tmr_expire)
  );

  thr_irq_status u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_down_i(ev_down), .ev_up_i(ev_up), .clr_i(irq_clr_i),
    .irq_o(irq_o), .irq_up_o(irq_up_o)
  );
endmodule

// File: tb/thr_throttle_ctrl_bench.sv
module thr_throttle_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int H  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot_i = 1'b0, tgt_wr_i = 1'b0, thr_wr_i = 1'b0, ack_i = 1'b0, irq_clr_i = 1'b0;
  logic [PW-1:0] tgt_pt_i = '0, thr_pt_i = '0;
  logic req_o, irq_o, irq_up_o;
  logic [PW-1:0] req_pt_o, cur_pt_o;

  thr_throttle_ctrl #(.PW(PW), .HOLD_CYC(H), .RESET_PT(8), .THR_RESET_PT(2)) u_thr_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i),
    .tgt_wr_i(tgt_wr_i), .tgt_pt_i(tgt_pt_i),
    .thr_wr_i(thr_wr_i), .thr_pt_i(thr_pt_i),
    .ack_i(ack_i), .req_o(req_o), .req_pt_o(req_pt_o), .cur_pt_o(cur_pt_o),
    .irq_o(irq_o), .irq_up_o(irq_up_o), .irq_clr_i(irq_clr_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [PW-1:0] pt; int gap; string tag; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_ack = 0, ack_lat = 1;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input int pt, input int gap, input string tag);
    exp_t e;
    e.pt = PW'(pt); e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: sequencer model and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && req_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected request", int'(req_pt_o), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(req_pt_o == e.pt, {e.tag, " request point"}, int'(req_pt_o), int'(e.pt));
          if (e.gap > 0)
            chk(cyc - last_ack == e.gap, {e.tag, " request timing"}, cyc - last_ack, e.gap);
        end
        repeat (ack_lat) @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        last_ack = cyc;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  task automatic set_target(input int pt);
    @(negedge clk); tgt_wr_i = 1'b1; tgt_pt_i = PW'(pt);
    @(negedge clk); tgt_wr_i = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq_o);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || req_o || ack_i);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_o == 1'b0, "R1 req_o", req_o, 0);
    chk(irq_o == 1'b0, "R1 irq_o", irq_o, 0);
    chk(irq_up_o == 1'b0, "R1 irq_up_o", irq_up_o, 0);
    chk(cur_pt_o == 4'd8, "R1 cur_pt_o", cur_pt_o, 8);

    // R2 plain software transition, no interrupt
    push(9, 0, "R2");
    set_target(9);
    wait_idle();
    chk(cur_pt_o == 4'd9, "R2 cur_pt_o", cur_pt_o, 9);
    chk(irq_o == 1'b0, "R2 no interrupt", irq_o, 0);

    // R3 / R5 / R7 throttle and restore after one hold
    push(2, 0, "R3");
    push(9, H, "R5");
    @(negedge clk); hot_i = 1'b1;
    wait_irq();
    hot_i = 1'b0;
    chk(irq_up_o == 1'b0, "R7 down direction", irq_up_o, 0);
    chk(cur_pt_o == 4'd2, "R3 throttled point", cur_pt_o, 2);
    clear_irq();
    chk(irq_o == 1'b0, "R7 cleared", irq_o, 0);
    wait_irq();
    chk(irq_up_o == 1'b1, "R7 up direction", irq_up_o, 1);
    chk(cur_pt_o == 4'd9, "R5 restored point", cur_pt_o, 9);
    clear_irq();
    wait_idle();

    // R6 still hot at first check: two full holds
    push(2, 0, "R6");
    push(9, 2*H, "R6");
    @(negedge clk); hot_i = 1'b1;
    wait_irq();
    clear_irq();
    repeat (H + H/2) @(negedge clk);
    hot_i = 1'b0;
    wait_irq();
    chk(cur_pt_o == 4'd9, "R6 restored point", cur_pt_o, 9);
    clear_irq();
    wait_idle();

    // R9 new throttle point, R8 writes during throttle queued (latest wins)
    @(negedge clk); thr_wr_i = 1'b1; thr_pt_i = 4'd1;
    @(negedge clk); thr_wr_i = 1'b0;
    push(1, 0, "R9");
    push(9, H, "R8");
    push(5, 1, "R8");
    @(negedge clk); hot_i = 1'b1;
    wait_irq();
    clear_irq();
    hot_i = 1'b0;
    set_target(6);
    set_target(5);
    wait_irq();
    chk(irq_up_o == 1'b1, "R8 up interrupt", irq_up_o, 1);
    clear_irq();
    wait_idle();
    chk(cur_pt_o == 4'd5, "R8 queued target applied", cur_pt_o, 5);

    // R10 hot and software write together: throttle first
    push(1, 0, "R10");
    push(5, H, "R10");
    push(7, 1, "R10");
    @(negedge clk); hot_i = 1'b1; tgt_wr_i = 1'b1; tgt_pt_i = 4'd7;
    @(negedge clk); tgt_wr_i = 1'b0;
    wait_irq();
    clear_irq();
    hot_i = 1'b0;
    wait_irq();
    clear_irq();
    wait_idle();
    chk(cur_pt_o == 4'd7, "R10 final point", cur_pt_o, 7);

    // R4 slow acknowledge; hot arriving while a software request is open
    ack_lat = 6;
    push(3, 0, "R4");
    push(1, 1, "R4");
    push(3, H, "R4");
    set_target(3);
    do @(negedge clk); while (!req_o);
    hot_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_o == 1'b1, "R4 request held", req_o, 1);
    chk(req_pt_o == 4'd3, "R4 point held", req_pt_o, 3);
    wait_irq();
    hot_i = 1'b0;
    clear_irq();
    wait_irq();
    clear_irq();
    wait_idle();
    chk(cur_pt_o == 4'd3, "R4 final point", cur_pt_o, 3);
    chk(exp_q.size() == 0, "R4 all expected requests seen", exp_q.size(), 0);

    done = 1;
    summary();
  end
endmodule